// File: doc/BRIEF.md
# Lockable Configurable Logic Array

This block turns small groups of general-purpose pins into free-running combinational gates. Each group has four pins: three gate inputs and one gate output. Every gate takes its function from an 8-bit truth table, so a single group can act as any gate of up to three inputs, including two-input XOR or XNOR. Adjacent groups form a pair. In a pair, the lower gate's result can be fed into the upper gate's first input, which gives a two-level gate. The intermediate term can be driven on the lower group's output pin, or that pin can be left to ordinary GPIO use.

Software controls the block through a simple register bus. Writes take one cycle. Reads return data one cycle after the request. An enable register picks which groups act as gates. A sticky, per-group lock register freezes that group's enable bit, its truth table and, for the upper group of a pair, the pair's cascade controls. A lock holds until the power-on flag is asserted. The external reset clears the lock only when a reset-mode bit in the configuration register allows it. Gate inputs are never claimed by the array. An input that a truth table ignores therefore stays a normal GPIO pin, and any pin, including a gate output, can be read back through the pin-status register.

Top module: `lockable_logic_array`

## Requirements
- R1: After the power-on flag (por_n low), every register reads 0 and no pin output enable is set.
- R2: When group k is enabled, pin 4k+3 drives bit (4a+2b+c) of truth-table register k, where a, b and c are the pad inputs of pins 4k, 4k+1 and 4k+2.
- R3: An enabled group forces its output pin's output enable to 1 whatever the direction register holds. A disabled group leaves that pin to the GPIO direction (0x05, 1 = output) and GPIO data (0x04) registers.
- R4: Pins 4k..4k+2 of an enabled group keep following the GPIO direction and data registers, and the gate sees the pad value that results.
- R5: When cascade bit p (register 0x03, bit p) is 1 and groups 2p and 2p+1 are both enabled, the upper gate uses the lower gate's result as input a in place of pin 8p+4.
- R6: With a cascade active, the lower output pin 8p+3 drives the intermediate term only when expose bit p (register 0x03, bit 4+p) is 1. Otherwise it follows GPIO.
- R7: With lock bit k (register 0x02) set, writes to enable bit k, to truth-table register 0x10+k and, for odd k, to the pair's cascade and expose bits complete without effect. Unlocked fields stay writable.
- R8: A lock bit, once 1, stays 1. Writing 0 to it has no effect.
- R9: The power-on flag clears all lock bits and the configuration register.
- R10: The external reset (rst_n low) clears the GPIO registers. It clears the lock bits, and with them the locked enable, truth-table and cascade state, only when configuration bit 0 (register 0x00) is 1. The configuration register survives it.
- R11: Register 0x06 returns the pad input vector, including gate outputs, on rdata one cycle after rd_en.
- R12: Writable registers read back their stored value. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| por_n | input | 1 | Synchronous active-low power-on flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| pad_in | input | PINS | Pin input levels |
| pad_out | output | PINS | Pin output levels |
| pad_oe | output | PINS | Pin output enables |

## Verification
The assertions take for granted that the power-on flag is asserted at start-up, before any write, and that no cascade is requested for an odd number of groups. The bench always opens with the power-on flag. It changes pad inputs and bus strobes only at falling clock edges, and it drives pad_in from a loop-back model: pins whose output enable is set return pad_out, and the remaining pins take external values. Resets are pulsed for whole cycles with the bus idle, so the freeze properties never see a write that coincides with a reset.

// File: rtl/lla_pkg.sv
// Package: register map and address width shared by the logic-array modules.
// Assumes an 8-bit address bus; offsets are fixed for software.
package lla_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_CFG   = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENA   = 8'h01;
    localparam logic [ADDR_W-1:0] A_LOCK  = 8'h02;
    localparam logic [ADDR_W-1:0] A_CASC  = 8'h03;
    localparam logic [ADDR_W-1:0] A_GOUT  = 8'h04;
    localparam logic [ADDR_W-1:0] A_GDIR  = 8'h05;
    localparam logic [ADDR_W-1:0] A_PIN   = 8'h06;
    localparam logic [ADDR_W-1:0] A_FUNC0 = 8'h10;
endpackage

// File: rtl/lla_regs.sv
// Module: register file with per-group sticky lock.
// Holds configuration, enable, lock, cascade, GPIO and truth-table registers.
// Assumes N_ARR even, N_ARR/2 <= 4, 4*N_ARR <= DATA_W, DATA_W >= 8.
module lla_regs
    import lla_pkg::*;
#(
    parameter int N_ARR  = 2,
    parameter int DATA_W = 8,
    localparam int PINS   = 4 * N_ARR,
    localparam int N_PAIR = N_ARR / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   por_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [PINS-1:0]        pin_in,
    output logic [DATA_W-1:0]      rdata,
    output logic [N_ARR-1:0]       ena_q,
    output logic [N_ARR-1:0][7:0]  func_q,
    output logic [N_PAIR-1:0]      casc_q,
    output logic [N_PAIR-1:0]      expose_q,
    output logic [PINS-1:0]        gout_q,
    output logic [PINS-1:0]        gdir_q
);
    logic             cfg_clr_q;
    logic [N_ARR-1:0] lock_q;
    logic [N_ARR-1:0] keep;
    logic [DATA_W-1:0] rd_mux;

    // Locked state that survives an external reset
    assign keep = lock_q & {N_ARR{~cfg_clr_q}};

    // Configuration: reset-mode bit, cleared by power-on only
    always_ff @(posedge clk) begin
        if (!por_n)
            cfg_clr_q <= 1'b0;
        else if (wr_en && addr == A_CFG)
            cfg_clr_q <= wdata[0];
    end

    // Lock bits: set-only, cleared by power-on or by a permitted reset
    always_ff @(posedge clk) begin
        if (!por_n)
            lock_q <= '0;
        else if (!rst_n)
            lock_q <= keep;
        else if (wr_en && addr == A_LOCK)
            lock_q <= lock_q | wdata[N_ARR-1:0];
    end

    // GPIO data and direction: cleared by either reset
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            gout_q <= '0;
            gdir_q <= '0;
        end else if (wr_en && addr == A_GOUT) begin
            gout_q <= wdata[PINS-1:0];
        end else if (wr_en && addr == A_GDIR) begin
            gdir_q <= wdata[PINS-1:0];
        end
    end

    for (genvar k = 0; k < N_ARR; k++) begin : g_grp
        localparam logic [ADDR_W-1:0] FA = A_FUNC0 + ADDR_W'(k);

        // Enable bit k: frozen while lock k is set
        always_ff @(posedge clk) begin
            if (!por_n)
                ena_q[k] <= 1'b0;
            else if (!rst_n)
                ena_q[k] <= keep[k] & ena_q[k];
            else if (wr_en && addr == A_ENA && !lock_q[k])
                ena_q[k] <= wdata[k];
        end

        // Truth table k: frozen while lock k is set
        always_ff @(posedge clk) begin
            if (!por_n)
                func_q[k] <= '0;
            else if (!rst_n)
                func_q[k] <= keep[k] ? func_q[k] : 8'h00;
            else if (wr_en && addr == FA && !lock_q[k])
                func_q[k] <= wdata[7:0];
        end

        AST_ENA_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
            (lock_q[k] && (rst_n || !cfg_clr_q)) |=> $stable(ena_q[k])) // R7
            else $error("enable bit changed while locked");
        AST_FUNC_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
            (lock_q[k] && (rst_n || !cfg_clr_q)) |=> $stable(func_q[k])) // R7
            else $error("truth table changed while locked");
        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
            (lock_q[k] && rst_n) |=> lock_q[k]) // R8
            else $error("lock bit cleared without reset");
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        // Cascade and expose bits of pair p: frozen by the upper group's lock
        always_ff @(posedge clk) begin
            if (!por_n) begin
                casc_q[p]   <= 1'b0;
                expose_q[p] <= 1'b0;
            end else if (!rst_n) begin
                casc_q[p]   <= keep[2*p+1] & casc_q[p];
                expose_q[p] <= keep[2*p+1] & expose_q[p];
            end else if (wr_en && addr == A_CASC && !lock_q[2*p+1]) begin
                casc_q[p]   <= wdata[p];
                expose_q[p] <= wdata[4+p];
            end
        end
    end

    // Read multiplexer over the register map
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CFG:  rd_mux[0]            = cfg_clr_q;
            A_ENA:  rd_mux[N_ARR-1:0]    = ena_q;
            A_LOCK: rd_mux[N_ARR-1:0]    = lock_q;
            A_CASC: begin
                rd_mux[N_PAIR-1:0]       = casc_q;
                rd_mux[4 +: N_PAIR]      = expose_q;
            end
            A_GOUT: rd_mux[PINS-1:0]     = gout_q;
            A_GDIR: rd_mux[PINS-1:0]     = gdir_q;
            A_PIN:  rd_mux[PINS-1:0]     = pin_in;
            default: rd_mux = '0;
        endcase
        for (int k = 0; k < N_ARR; k++) begin
            if (addr == A_FUNC0 + ADDR_W'(k))
                rd_mux[7:0] = func_q[k];
        end
    end

    // Read data register: one-cycle latency after rd_en
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !por_n |=> (lock_q == '0 && !cfg_clr_q)) // R9
        else $error("power-on did not clear lock");
endmodule

// File: rtl/lla_gate.sv
// Module: one truth-table gate with an optional cascaded first input.
// Assumes func holds the output for index {a,b,c}, a as most significant bit.
module lla_gate (
    input  logic [7:0] func,
    input  logic       a,
    input  logic       b,
    input  logic       c,
    input  logic       casc_sel,
    input  logic       casc_in,
    output logic       y
);
    logic       a_eff;
    logic [2:0] idx;

    // Select the first input and look up the truth table
    always_comb begin
        a_eff = casc_sel ? casc_in : a;
        idx   = {a_eff, b, c};
        y     = func[idx];
    end
endmodule

// File: rtl/lla_pinmux.sv
// Module: merges gate outputs with the GPIO path onto the pins.
// Assumes pin 4k+3 is the output of group k; inputs are never claimed.
module lla_pinmux #(
    parameter int N_ARR = 2,
    localparam int PINS   = 4 * N_ARR,
    localparam int N_PAIR = N_ARR / 2
) (
    input  logic [N_ARR-1:0]  ena,
    input  logic [N_PAIR-1:0] casc,
    input  logic [N_PAIR-1:0] expose,
    input  logic [N_ARR-1:0]  gate_y,
    input  logic [PINS-1:0]   gout,
    input  logic [PINS-1:0]   gdir,
    output logic [N_PAIR-1:0] casc_act,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    logic [N_ARR-1:0] drive;

    // Cascade is live only when both groups of the pair are enabled
    always_comb begin
        for (int p = 0; p < N_PAIR; p++)
            casc_act[p] = casc[p] & ena[2*p] & ena[2*p+1];
    end

    // Decide which groups own their output pin
    always_comb begin
        for (int k = 0; k < N_ARR; k++) begin
            if (k % 2 == 0)
                drive[k] = ena[k] & ~(casc_act[k/2] & ~expose[k/2]);
            else
                drive[k] = ena[k];
        end
    end

    // Pin drivers: gate result where owned, GPIO elsewhere
    always_comb begin
        pad_out = gout;
        pad_oe  = gdir;
        for (int k = 0; k < N_ARR; k++) begin
            if (drive[k]) begin
                pad_out[4*k+3] = gate_y[k];
                pad_oe[4*k+3]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lockable_logic_array.sv
// Module: top of the lockable configurable logic array.
// Groups of four pins become truth-table gates; pairs may cascade.
// Assumes N_ARR even and 4*N_ARR <= DATA_W; both resets synchronous active-low.
module lockable_logic_array
    import lla_pkg::*;
#(
    parameter int N_ARR  = 2,
    parameter int DATA_W = 8,
    localparam int PINS   = 4 * N_ARR,
    localparam int N_PAIR = N_ARR / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    logic [N_ARR-1:0]      ena_q;
    logic [N_ARR-1:0][7:0] func_q;
    logic [N_PAIR-1:0]     casc_q;
    logic [N_PAIR-1:0]     expose_q;
    logic [N_PAIR-1:0]     casc_act;
    logic [PINS-1:0]       gout_q;
    logic [PINS-1:0]       gdir_q;
    logic [N_ARR-1:0]      gate_y;

    lla_regs #(.N_ARR(N_ARR), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .pin_in(pad_in), .rdata(rdata),
        .ena_q(ena_q), .func_q(func_q), .casc_q(casc_q), .expose_q(expose_q),
        .gout_q(gout_q), .gdir_q(gdir_q)
    );

    for (genvar k = 0; k < N_ARR; k++) begin : g_gate
        logic sel;
        logic cin;
        if (k % 2 == 1) begin : g_upper
            assign sel = casc_act[k/2];
            assign cin = gate_y[k-1];
        end else begin : g_lower
            assign sel = 1'b0;
            assign cin = 1'b0;
        end
        lla_gate gate_i (
            .func(func_q[k]), .a(pad_in[4*k]), .b(pad_in[4*k+1]),
            .c(pad_in[4*k+2]), .casc_sel(sel), .casc_in(cin), .y(gate_y[k])
        );

        if (k % 2 == 1) begin : g_chk_up
            AST_UPPER_OWNS_PIN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
                ena_q[k] |-> pad_oe[4*k+3]) // R3
                else $error("enabled group does not drive its pin");
        end else begin : g_chk_lo
            AST_LOWER_OWNS_PIN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
                (ena_q[k] && !casc_q[k/2]) |-> pad_oe[4*k+3]) // R3
                else $error("enabled group does not drive its pin");
        end
    end

    lla_pinmux #(.N_ARR(N_ARR)) mux_i (
        .ena(ena_q), .casc(casc_q), .expose(expose_q), .gate_y(gate_y),
        .gout(gout_q), .gdir(gdir_q), .casc_act(casc_act),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pchk
        AST_HIDDEN_MID_IS_GPIO: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
            (casc_q[p] && ena_q[2*p] && ena_q[2*p+1] && !expose_q[p])
                |-> (pad_oe[8*p+3] == gdir_q[8*p+3])) // R6
            else $error("hidden intermediate pin not returned to GPIO");
    end
endmodule

// File: tb/lockable_logic_array_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module lockable_logic_array_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] ext = '0;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    lockable_logic_array dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic tt(input logic [7:0] f, input logic a, input logic b, input logic c);
        return f[{a, b, c}];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic do_rst();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_por();
        ext = 8'h00;
        for (int a = 0; a < 8; a++) begin
            rd(8'(a), d); chk("R1 reg after power-on", 16'(d), 16'h0);
        end
        rd(8'h10, d); chk("R1 func0 after power-on", 16'(d), 16'h0);
        rd(8'h11, d); chk("R1 func1 after power-on", 16'(d), 16'h0);
        chk("R1 pad_oe after power-on", 16'(pad_oe), 16'h0);
    endtask

    task automatic t_func();
        wr(8'h10, 8'h3C);
        wr(8'h01, 8'h01);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk); ext = 8'(v); #1;
            chk("R2 xor on group0", 16'(pad_out[3]), 16'(tt(8'h3C, v[0], v[1], v[2])));
            chk("R3 group0 pin forced out", 16'(pad_oe[3]), 16'h1);
        end
        wr(8'h11, 8'h80);
        wr(8'h01, 8'h03);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk); ext = 8'(v << 4); #1;
            chk("R2 and3 on group1", 16'(pad_out[7]), 16'(v == 7));
        end
        wr(8'h10, 8'hC3);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); ext = 8'(v); #1;
            chk("R2 xnor on group0", 16'(pad_out[3]), 16'(v[0] == v[1]));
        end
        wr(8'h01, 8'h02);
        wr(8'h04, 8'h08);
        #1;
        chk("R3 disabled pin follows dir", 16'(pad_oe[3]), 16'h0);
        wr(8'h05, 8'h08);
        #1;
        chk("R3 disabled pin follows gpio", 16'({pad_oe[3], pad_out[3]}), 16'h3);
        wr(8'h05, 8'h00); wr(8'h04, 8'h00); wr(8'h01, 8'h00);
    endtask

    task automatic t_gpio();
        wr(8'h10, 8'h3C);
        wr(8'h01, 8'h01);
        wr(8'h05, 8'h02);
        wr(8'h04, 8'h02);
        @(negedge clk); ext = 8'h00; #1;
        chk("R4 gate input pin still driven as gpio", 16'({pad_oe[1], pad_out[1]}), 16'h3);
        chk("R4 gate sees gpio-driven b", 16'(pad_out[3]), 16'h1);
        wr(8'h04, 8'h00); #1;
        chk("R4 gpio data change reaches gate", 16'(pad_out[3]), 16'h0);
        wr(8'h05, 8'h00); wr(8'h01, 8'h00);
    endtask

    task automatic t_cascade();
        wr(8'h10, 8'h80);
        wr(8'h11, 8'h3C);
        wr(8'h01, 8'h03);
        wr(8'h03, 8'h01);
        for (int v = 0; v < 16; v++) begin
            logic lo;
            @(negedge clk); ext = {1'b0, v[3], 1'b0, v[2], 1'b0, 3'(v)}; #1;
            lo = (v[2:0] == 3'b111);
            chk("R5 cascade upper output", 16'(pad_out[7]), 16'(lo ^ 1'b0));
            chk("R6 hidden mid pin is gpio", 16'(pad_oe[3]), 16'h0);
        end
        @(negedge clk); ext = 8'h27; #1;
        chk("R5 cascade with b set", 16'(pad_out[7]), 16'h0);
        @(negedge clk); ext = 8'h17; #1;
        chk("R5 pin a ignored under cascade", 16'(pad_out[7]), 16'h1);
        wr(8'h03, 8'h11);
        @(negedge clk); ext = 8'h07; #1;
        chk("R6 exposed mid pin", 16'({pad_oe[3], pad_out[3]}), 16'h3);
        wr(8'h03, 8'h00); wr(8'h01, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        wr(8'h10, 8'h5A);
        wr(8'h01, 8'h03);
        wr(8'h02, 8'h01);
        wr(8'h10, 8'h00);
        rd(8'h10, d); chk("R7 locked func write ignored", 16'(d), 16'h5A);
        wr(8'h01, 8'h00);
        rd(8'h01, d); chk("R7 locked enable kept, unlocked cleared", 16'(d), 16'h1);
        wr(8'h11, 8'h66);
        rd(8'h11, d); chk("R7 unlocked func writable", 16'(d), 16'h66);
        wr(8'h03, 8'h11);
        rd(8'h03, d); chk("R7 cascade writable while upper unlocked", 16'(d), 16'h11);
        wr(8'h02, 8'h00);
        rd(8'h02, d); chk("R8 lock not cleared by writing 0", 16'(d), 16'h1);
        wr(8'h02, 8'h02);
        wr(8'h03, 8'h00);
        rd(8'h03, d); chk("R7 cascade frozen by upper lock", 16'(d), 16'h11);
        rd(8'h02, d); chk("R8 both locks set", 16'(d), 16'h3);
    endtask

    task automatic t_rst_keep();
        logic [7:0] d;
        wr(8'h05, 8'h40);
        do_rst();
        rd(8'h02, d); chk("R10 lock kept when reset mode off", 16'(d), 16'h3);
        rd(8'h10, d); chk("R10 locked func kept", 16'(d), 16'h5A);
        rd(8'h01, d); chk("R10 locked enable kept", 16'(d), 16'h1);
        rd(8'h05, d); chk("R10 gpio dir cleared", 16'(d), 16'h0);
    endtask

    task automatic t_rst_clear();
        logic [7:0] d;
        wr(8'h00, 8'h01);
        do_rst();
        rd(8'h02, d); chk("R10 lock cleared when reset mode on", 16'(d), 16'h0);
        rd(8'h10, d); chk("R10 func cleared with lock", 16'(d), 16'h0);
        rd(8'h03, d); chk("R10 cascade cleared with lock", 16'(d), 16'h0);
        rd(8'h00, d); chk("R10 config survives reset", 16'(d), 16'h1);
    endtask

    task automatic t_por();
        logic [7:0] d;
        wr(8'h02, 8'h03);
        do_por();
        rd(8'h02, d); chk("R9 power-on clears lock", 16'(d), 16'h0);
        rd(8'h00, d); chk("R9 power-on clears config", 16'(d), 16'h0);
        wr(8'h10, 8'hAA);
        rd(8'h10, d); chk("R9 func writable after power-on", 16'(d), 16'hAA);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(8'h10, 8'hFE);
        wr(8'h01, 8'h01);
        @(negedge clk); ext = 8'h52;
        rd(8'h06, d); chk("R11 pin readback includes gate output", 16'(d), 16'h5A);
        wr(8'h04, 8'hC3);
        rd(8'h04, d); chk("R12 gpio data reads back", 16'(d), 16'hC3);
        rd(8'h3F, d); chk("R12 unmapped reads zero", 16'(d), 16'h0);
        @(negedge clk); rd_en = 1'b1; addr = 8'h01;
        @(posedge clk); #1; chk("R11 read data after one cycle", 16'(rdata), 16'h1);
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_func();
        t_gpio();
        t_cascade();
        t_lock();
        t_rst_keep();
        t_rst_clear();
        t_por();
        t_readback();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule